// File: doc/BRIEF.md
# Frame Idle Watchdog for Audio Inputs

This block supervises a set of audio input streams running on a fast hub clock. Each input owns a cycle counter that restarts on every frame-start strobe for that input. When the counter runs past a programmed limit before the next frame arrives, the block clears that input's enable on its own and raises a sticky status bit for it. The limit is a count of hub clock cycles and is set to the hub clock frequency divided by the sample rate. For example, a 49.152 MHz hub clock and 8 kHz audio give 6144 (0x1800).

Software reaches the block through a small word-addressed register port: a global arm bit, the per-input enable bits, the sticky status bits, one limit register per input and one read-only last-period register per input. The enable bits and the one-cycle enable-clear strobes are the block's outputs to the stream logic. Frame strobes arrive already in the hub clock domain.

Top module: `frame_idle_wdog`

## Requirements
- R1: After reset the global arm bit is 0, all input enables are 0, all status bits are 0, every last-period register reads 0 and every limit register reads DEF_LIMIT (default 6144).
- R2: Register map, word addresses, read combinationally on rd_data: 0 = arm (bit 0); 1 = input enables (bit i = input i); 2 = status (bit i); 4+i = limit of input i; 4+NUM_IN+i = last period of input i (8..11 by default). Unused bits and addresses read 0.
- R3: An input's counter advances only while that input is enabled. A strobe on an enabled input stores the number of cycles since the previous restart into its last-period register and restarts the count. Strobes on consecutive clock cycles store 1. The first strobe after enabling measures from the enabling edge.
- R4: With arm = 1, a non-zero limit L and the input enabled, the input's enable clears at the clock edge where L cycles have passed since the last restart with no strobe. Strobes spaced exactly L cycles apart never trigger this.
- R5: en_clr[i] is high for the single cycle after input i expires, that is, during the first cycle in which the cleared enable is visible.
- R6: Each expiry sets status bit i, which stays set until software writes 1 to that bit at address 2. Writing 0 to it has no effect.
- R7: With arm = 0 no input is ever disabled by the block. Counting and last-period capture still work.
- R8: A limit of 0 turns off expiry for that input.
- R9: An expired input stays disabled, and ignores frame strobes, until software writes 1 to its enable bit. A software write to the enable register in the same cycle as an expiry wins, while the status bit is still set.
- R10: An expiry on one input leaves the enables of the other inputs unchanged.
- R11: A strobe on a disabled input leaves its last-period register unchanged.
- R12: The counter saturates at 2^CNT_W-1, and the last-period register then captures 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Hub clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | NUM_IN | Per-input frame-start strobes |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | CNT_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | CNT_W | Register read data |
| in_en | output | NUM_IN | Current enable of each input |
| en_clr | output | NUM_IN | One-cycle strobe after each automatic disable |
| wd_stat | output | NUM_IN | Sticky expiry status |

## Verification
The hardest case to reach is an expiry that lands in the same clock cycle as a software write to the enable register. The stimulus gets there by enabling one input with a limit of 4 and then repeating the enable write exactly four cycles later, so the write and the expiry meet on the same edge. The exact-limit boundary is reached with strobes spaced precisely L cycles apart, followed by one gap of L+1 or more. Saturation comes from letting a disarmed, enabled input count idle for over 65,535 cycles. A behavioural model is compared with the outputs and the read port every cycle, so coincidences caused by stray expiries on the other inputs are covered as well.

// File: rtl/fiw_pkg.sv
package fiw_pkg;
   localparam int unsigned REG_ARM      = 0;
   localparam int unsigned REG_EN       = 1;
   localparam int unsigned REG_STAT     = 2;
   localparam int unsigned REG_LIM_BASE = 4;

   function automatic int unsigned last_base(input int unsigned n_in);
      return REG_LIM_BASE + n_in;
   endfunction
endpackage

// File: rtl/fiw_lane.sv
module fiw_lane #(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned DEF_LIMIT = 6144
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             strobe,
   input  logic             lim_we,
   input  logic             en_we,
   input  logic             en_wval,
   input  logic             stat_clr,
   input  logic [CNT_W-1:0] wdata,
   output logic             en_q,
   output logic             stat_q,
   output logic             clr_q,
   output logic [CNT_W-1:0] limit_q,
   output logic [CNT_W-1:0] last_q
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;
   localparam logic [CNT_W-1:0] LIM_RST = CNT_W'(DEF_LIMIT);

   logic [CNT_W-1:0] cnt_q;
   logic             at_max;
   logic             expire;

   assign at_max = (cnt_q == CNT_MAX);
   assign expire = en_q && arm && (limit_q != '0) && !strobe
                   && (cnt_q >= limit_q - 1'b1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         last_q  <= '0;
         limit_q <= LIM_RST;
         en_q    <= 1'b0;
         stat_q  <= 1'b0;
         clr_q   <= 1'b0;
      end else begin
         clr_q <= expire;
         if (lim_we) limit_q <= wdata;
         if (en_we)       en_q <= en_wval;
         else if (expire) en_q <= 1'b0;
         if (expire)        stat_q <= 1'b1;
         else if (stat_clr) stat_q <= 1'b0;
         if (!en_q || expire) begin
            cnt_q <= '0;
         end else if (strobe) begin
            last_q <= at_max ? cnt_q : cnt_q + 1'b1;
            cnt_q  <= '0;
         end else if (!at_max) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/fiw_rdmux.sv
module fiw_rdmux
   import fiw_pkg::*;
#(
   parameter int unsigned NUM_IN = 4,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 4
) (
   input  logic                         arm,
   input  logic [NUM_IN-1:0]            en_vec,
   input  logic [NUM_IN-1:0]            stat_vec,
   input  logic [NUM_IN-1:0][CNT_W-1:0] lim_vec,
   input  logic [NUM_IN-1:0][CNT_W-1:0] last_vec,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [CNT_W-1:0]             rd_data
);
   localparam int unsigned LAST_BASE = last_base(NUM_IN);

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(REG_ARM))  rd_data[0] = arm;
      if (rd_addr == ADDR_W'(REG_EN))   rd_data[NUM_IN-1:0] = en_vec;
      if (rd_addr == ADDR_W'(REG_STAT)) rd_data[NUM_IN-1:0] = stat_vec;
      for (int i = 0; i < NUM_IN; i++) begin
         if (rd_addr == ADDR_W'(REG_LIM_BASE + i)) rd_data = lim_vec[i];
         if (rd_addr == ADDR_W'(LAST_BASE + i))    rd_data = last_vec[i];
      end
   end
endmodule

// File: rtl/frame_idle_wdog.sv
module frame_idle_wdog
   import fiw_pkg::*;
#(
   parameter int unsigned NUM_IN    = 4,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned DEF_LIMIT = 6144,
   localparam int unsigned ADDR_W   = $clog2(REG_LIM_BASE + 2 * NUM_IN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] frame_start,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   output logic [NUM_IN-1:0] in_en,
   output logic [NUM_IN-1:0] en_clr,
   output logic [NUM_IN-1:0] wd_stat
);
   if (NUM_IN < 1 || NUM_IN > 16) begin : g_bad_num
      $error("NUM_IN must lie in 1..16");
   end
   if (CNT_W < NUM_IN || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must cover NUM_IN and be at most 32");
   end
   if (DEF_LIMIT >= (64'd1 << CNT_W)) begin : g_bad_def
      $error("DEF_LIMIT does not fit in CNT_W bits");
   end

   logic                         arm_q;
   logic                         arm_we, en_we, stat_we;
   logic [NUM_IN-1:0][CNT_W-1:0] lim_vec;
   logic [NUM_IN-1:0][CNT_W-1:0] last_vec;

   assign arm_we  = wr_en && (wr_addr == ADDR_W'(REG_ARM));
   assign en_we   = wr_en && (wr_addr == ADDR_W'(REG_EN));
   assign stat_we = wr_en && (wr_addr == ADDR_W'(REG_STAT));

   always_ff @(posedge clk) begin
      if (!rst_n)      arm_q <= 1'b0;
      else if (arm_we) arm_q <= wr_data[0];
   end

   for (genvar i = 0; i < NUM_IN; i++) begin : g_lane
      fiw_lane #(.CNT_W(CNT_W), .DEF_LIMIT(DEF_LIMIT)) u_lane (
         .clk      (clk),
         .rst_n    (rst_n),
         .arm      (arm_q),
         .strobe   (frame_start[i]),
         .lim_we   (wr_en && (wr_addr == ADDR_W'(REG_LIM_BASE + i))),
         .en_we    (en_we),
         .en_wval  (wr_data[i]),
         .stat_clr (stat_we && wr_data[i]),
         .wdata    (wr_data),
         .en_q     (in_en[i]),
         .stat_q   (wd_stat[i]),
         .clr_q    (en_clr[i]),
         .limit_q  (lim_vec[i]),
         .last_q   (last_vec[i])
      );
   end

   fiw_rdmux #(.NUM_IN(NUM_IN), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rd (
      .arm      (arm_q),
      .en_vec   (in_en),
      .stat_vec (wd_stat),
      .lim_vec  (lim_vec),
      .last_vec (last_vec),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data)
   );
endmodule

// File: rtl/fiw_chk.sv
module fiw_chk
   import fiw_pkg::*;
#(
   parameter int unsigned NUM_IN = 4,
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              arm,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [CNT_W-1:0]  wr_data,
   input logic [NUM_IN-1:0] in_en,
   input logic [NUM_IN-1:0] en_clr,
   input logic [NUM_IN-1:0] wd_stat
);
   logic en_wr, stat_wr;
   assign en_wr   = wr_en && (wr_addr == ADDR_W'(REG_EN));
   assign stat_wr = wr_en && (wr_addr == ADDR_W'(REG_STAT));

   for (genvar i = 0; i < NUM_IN; i++) begin : g_chk
      p_clr_drops_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (en_clr[i] && !$past(en_wr)) |-> !in_en[i]);
      p_clr_sets_stat_r5: assert property (@(posedge clk) disable iff (!rst_n)
         en_clr[i] |-> wd_stat[i]);
      p_sticky_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(wd_stat[i]) |-> $past(stat_wr && wr_data[i]));
      p_arm_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
         en_clr[i] |-> $past(arm));
      p_no_self_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(in_en[i]) |-> $past(en_wr && wr_data[i]));
   end
endmodule

bind frame_idle_wdog fiw_chk #(.NUM_IN(NUM_IN), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .arm     (arm_q),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .in_en   (in_en),
   .en_clr  (en_clr),
   .wd_stat (wd_stat)
);

// File: tb/sim_frame_idle_wdog.sv
`timescale 1ns/1ps
module sim_frame_idle_wdog;
   localparam int N    = 4;
   localparam int W    = 16;
   localparam int AW   = 4;
   localparam int MAXC = 65535;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  fs = '0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [W-1:0]  rd_data;
   logic [N-1:0]  in_en, en_clr, wd_stat;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   int m_cnt[N], m_last[N], m_lim[N];
   bit m_en[N], m_stat[N], m_clr[N];
   bit m_arm;

   always #2.5 clk = ~clk;

   frame_idle_wdog u0 (
      .clk(clk), .rst_n(rst_n), .frame_start(fs), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .in_en(in_en), .en_clr(en_clr), .wd_stat(wd_stat)
   );

   // behavioural reference, advanced on every rising edge
   always @(posedge clk) begin
      bit ex[N];
      cyc++;
      if (!rst_n) begin
         m_arm = 0;
         for (int i = 0; i < N; i++) begin
            m_cnt[i] = 0; m_last[i] = 0; m_lim[i] = 6144;
            m_en[i] = 0; m_stat[i] = 0; m_clr[i] = 0;
         end
      end else begin
         for (int i = 0; i < N; i++)
            ex[i] = m_en[i] && m_arm && (m_lim[i] != 0) && !fs[i]
                    && (m_cnt[i] + 1 >= m_lim[i]);
         for (int i = 0; i < N; i++) begin
            if (!m_en[i] || ex[i]) m_cnt[i] = 0;
            else if (fs[i]) begin
               m_last[i] = (m_cnt[i] == MAXC) ? MAXC : m_cnt[i] + 1;
               m_cnt[i] = 0;
            end else if (m_cnt[i] < MAXC) m_cnt[i]++;
            if (ex[i]) m_stat[i] = 1;
            else if (wr_en && wr_addr == 2 && wr_data[i]) m_stat[i] = 0;
            if (wr_en && wr_addr == 1) m_en[i] = wr_data[i];
            else if (ex[i]) m_en[i] = 0;
            if (wr_en && int'(wr_addr) == 4 + i) m_lim[i] = int'(wr_data);
            m_clr[i] = ex[i];
         end
         if (wr_en && wr_addr == 0) m_arm = wr_data[0];
      end
   end

   function automatic int exp_rd(int a);
      int v = 0;
      if (a == 0) v = int'(m_arm);
      if (a == 1) for (int i = 0; i < N; i++) v |= int'(m_en[i]) << i;
      if (a == 2) for (int i = 0; i < N; i++) v |= int'(m_stat[i]) << i;
      if (a >= 4 && a < 4 + N) v = m_lim[a-4];
      if (a >= 4 + N && a < 4 + 2*N) v = m_last[a-4-N];
      return v;
   endfunction

   task automatic chk(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the model
   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         for (int i = 0; i < N; i++) begin
            chk("R4 in_en", int'(in_en[i]), int'(m_en[i]));
            chk("R6 wd_stat", int'(wd_stat[i]), int'(m_stat[i]));
            chk("R5 en_clr", int'(en_clr[i]), int'(m_clr[i]));
         end
         chk("R2 rd_data", int'(rd_data), exp_rd(int'(rd_addr)));
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(int a, int d);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = W'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic strobe(logic [N-1:0] m);
      fs = m;
      @(negedge clk);
      fs = '0;
   endtask

   task automatic rdchk(int a, int mask, int exp, string tag);
      rd_addr = AW'(a);
      #1;
      chk(tag, int'(rd_data) & mask, exp);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1: reset state
      chk("R1 in_en", int'(in_en), 0);
      chk("R1 wd_stat", int'(wd_stat), 0);
      chk("R1 en_clr", int'(en_clr), 0);
      for (int a = 0; a < 3; a++) rdchk(a, 'hffff, 0, "R1 ctl");
      for (int a = 4; a < 8; a++) rdchk(a, 'hffff, 6144, "R1 limit");
      for (int a = 8; a < 12; a++) rdchk(a, 'hffff, 0, "R1 last");

      // R11: strobe on a disabled input
      strobe(4'h1);
      rdchk(8, 'hffff, 0, "R11");
      // R3: measured period
      wr(1, 1);
      strobe(4'h1); idle(6); strobe(4'h1);
      rdchk(8, 'hffff, 7, "R3");

      // R4: exact-limit spacing survives, longer gap expires
      wr(4, 10); wr(5, 0); wr(1, 3);
      strobe(4'h1); wr(0, 1); idle(8); strobe(4'h1);
      idle(9); strobe(4'h1);
      rdchk(8, 'hffff, 10, "R3 spacing");
      rdchk(1, 'hffff, 3, "R4 boundary");
      idle(20);
      rdchk(1, 'hffff, 2, "R10");
      rdchk(2, 'hffff, 1, "R6 set");

      // R6: write-one-to-clear
      wr(2, 0); rdchk(2, 'hffff, 1, "R6 w0");
      wr(2, 1); rdchk(2, 'hffff, 0, "R6 w1c");

      // R9: stays off until software re-enables
      idle(15); strobe(4'h1);
      rdchk(1, 'hffff, 2, "R9 stays off");
      rdchk(8, 'hffff, 10, "R11 after expiry");
      wr(1, 3); rdchk(1, 'hffff, 3, "R9 re-enable");

      // R8: zero limit never expires
      idle(50);
      rdchk(1, 2, 2, "R8");

      // R9: software write coincides with expiry
      wr(7, 4); wr(1, 'hB); idle(3); wr(1, 'hB);
      rdchk(1, 8, 8, "R9 write wins");
      rdchk(2, 8, 8, "R9 status still set");

      // R7: disarmed, nothing expires
      wr(0, 0); wr(6, 5); wr(1, 'hF);
      idle(30);
      rdchk(1, 'hffff, 15, "R7 no expiry");
      strobe(4'h4); idle(2); strobe(4'h4);
      rdchk(10, 'hffff, 3, "R7 capture");
      rdchk(6, 'hffff, 5, "R2 limit2");
      rdchk(7, 'hffff, 4, "R2 limit3");

      // R12: saturation
      strobe(4'h1); idle(70000); strobe(4'h1);
      rdchk(8, 'hffff, 65535, "R12");

      idle(2);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      wait (cyc > 150000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d expected=<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule